// File: doc/BRIEF.md
# DMA Channel Address Generator with Start-Address Reload

This block produces the source and destination addresses that one DMA channel presents on each access. Each side has its own stepping mode: hold, count up, or count down. When a side counts, its address moves by one element after every access. The element size is shared by both sides and may be 1, 2, 4 or 8 bytes.

When software programs a start address, the block also keeps a copy of it. Each side can then return to that start address at a boundary it selects on its own: after every burst, after every block, at the end of the whole transaction, or never. The surrounding channel logic supplies an access strobe and three boundary strobes. Bus access, arbitration and transfer counting are handled outside this block.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released, both the saved start address and the current address of each side are zero.
- R2: A load strobe for a side stores `load_val` as both that side's start address and its current address, visible on the next cycle. A load overrides a reload and an access on that side in the same cycle.
- R3: With mode code 00 or 11 (hold), an access leaves that side's address unchanged.
- R4: With mode code 01 (up), each access adds one step to that side's address.
- R5: With mode code 10 (down), each access subtracts one step from that side's address.
- R6: The step in bytes is 1, 2, 4 or 8 for `elem_size` codes 0, 1, 2 and 3.
- R7: Addresses are 24 bits wide and wrap modulo 2^24 in both directions.
- R8: The reload code is 2 bits: 00 never, 01 burst, 10 block, 11 transaction. A reload sets the current address back to the saved start address on the next cycle.
- R9: Boundaries nest. A burst reload fires on any of the burst-end, block-end or transaction-end strobes. A block reload fires on block-end or transaction-end. A transaction reload fires on transaction-end only.
- R10: When a reload fires in the same cycle as an access, the reload wins and the address equals the start address.
- R11: The two sides are independent. Any mode, reload code or load strobe on one side has no effect on the other side's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_src | input | 1 | Store `load_val` as the source start and current address |
| load_dst | input | 1 | Store `load_val` as the destination start and current address |
| load_val | input | 24 | Start address value to load |
| src_mode | input | 2 | Source stepping mode (00 hold, 01 up, 10 down, 11 hold) |
| dst_mode | input | 2 | Destination stepping mode, same codes as the source |
| src_reload | input | 2 | Source reload boundary (00 never, 01 burst, 10 block, 11 transaction) |
| dst_reload | input | 2 | Destination reload boundary, same codes as the source |
| elem_size | input | 2 | Element size code; step is 1 << code bytes |
| access | input | 1 | One access completed this cycle |
| burst_end | input | 1 | A burst ends this cycle |
| block_end | input | 1 | A block ends this cycle |
| txn_end | input | 1 | The transaction ends this cycle |
| src_addr | output | 24 | Current source address |
| dst_addr | output | 24 | Current destination address |

## Verification
Each side holds two registers, and only the current address can be seen at the ports. A corrupted start copy therefore stays hidden until the next reload on that side. When it fires, the cycle after the boundary strobe returns a wrong address. A wrong step or mode decode shows up on the cycle after the first access, and it is carried forward into every later address. For that reason the bench compares both addresses on every clock, so each fault is caught on the first cycle it appears.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD     = 2'b00,
        STEP_UP       = 2'b01,
        STEP_DOWN     = 2'b10,
        STEP_HOLD_ALT = 2'b11
    } step_mode_e;

    typedef enum logic [1:0] {
        RLD_NEVER = 2'b00,
        RLD_BURST = 2'b01,
        RLD_BLOCK = 2'b10,
        RLD_TXN   = 2'b11
    } reload_sel_e;

endpackage

// File: rtl/dma_agen_step.sv
module dma_agen_step #(
    parameter int AW     = 24,
    parameter int SIZE_W = 2
) (
    input  logic [SIZE_W-1:0] elem_size,
    output logic [AW-1:0]     step
);
    // Step in bytes is a power of two chosen by the size code.
    always_comb begin
        step = AW'(1) << elem_size;
    end
endmodule

// File: rtl/dma_agen_reload_dec.sv
module dma_agen_reload_dec
    import dma_agen_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       burst_end,
    input  logic       block_end,
    input  logic       txn_end,
    output logic       fire
);
    // Coarser boundaries also close the finer ones.
    always_comb begin
        case (reload_sel_e'(sel))
            RLD_BURST: fire = burst_end | block_end | txn_end;
            RLD_BLOCK: fire = block_end | txn_end;
            RLD_TXN:   fire = txn_end;
            default:   fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_agen_side.sv
module dma_agen_side
    import dma_agen_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic [1:0]    mode,
    input  logic [1:0]    reload_sel,
    input  logic [AW-1:0] step,
    input  logic          access,
    input  logic          burst_end,
    input  logic          block_end,
    input  logic          txn_end,
    output logic [AW-1:0] addr
);
    typedef struct packed {
        logic [AW-1:0] start;
        logic [AW-1:0] cur;
    } side_t;

    side_t side_d, side_q;
    logic  reload_fire;

    dma_agen_reload_dec i_reload_dec (
        .sel       (reload_sel),
        .burst_end (burst_end),
        .block_end (block_end),
        .txn_end   (txn_end),
        .fire      (reload_fire)
    );

    // Priority: load, then reload, then access stepping.
    always_comb begin
        side_d = side_q;
        if (load) begin
            side_d.start = load_val;
            side_d.cur   = load_val;
        end else if (reload_fire) begin
            side_d.cur = side_q.start;
        end else if (access) begin
            case (step_mode_e'(mode))
                STEP_UP:   side_d.cur = side_q.cur + step;
                STEP_DOWN: side_d.cur = side_q.cur - step;
                default:   side_d.cur = side_q.cur;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            side_q <= '0;
        end else begin
            side_q <= side_d;
        end
    end

    assign addr = side_q.cur;
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
    parameter int AW     = 24,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_src,
    input  logic              load_dst,
    input  logic [AW-1:0]     load_val,
    input  logic [1:0]        src_mode,
    input  logic [1:0]        dst_mode,
    input  logic [1:0]        src_reload,
    input  logic [1:0]        dst_reload,
    input  logic [SIZE_W-1:0] elem_size,
    input  logic              access,
    input  logic              burst_end,
    input  logic              block_end,
    input  logic              txn_end,
    output logic [AW-1:0]     src_addr,
    output logic [AW-1:0]     dst_addr
);
    localparam int NSIDE = 2;

    logic [AW-1:0] step;
    logic          side_load   [NSIDE];
    logic [1:0]    side_mode   [NSIDE];
    logic [1:0]    side_reload [NSIDE];
    logic [AW-1:0] side_addr   [NSIDE];

    assign side_load[0]   = load_src;
    assign side_load[1]   = load_dst;
    assign side_mode[0]   = src_mode;
    assign side_mode[1]   = dst_mode;
    assign side_reload[0] = src_reload;
    assign side_reload[1] = dst_reload;

    dma_agen_step #(.AW(AW), .SIZE_W(SIZE_W)) i_step (
        .elem_size (elem_size),
        .step      (step)
    );

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dma_agen_side #(.AW(AW)) i_side (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (side_load[g]),
            .load_val   (load_val),
            .mode       (side_mode[g]),
            .reload_sel (side_reload[g]),
            .step       (step),
            .access     (access),
            .burst_end  (burst_end),
            .block_end  (block_end),
            .txn_end    (txn_end),
            .addr       (side_addr[g])
        );
    end

    assign src_addr = side_addr[0];
    assign dst_addr = side_addr[1];
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
    parameter int AW     = 24,
    parameter int SIZE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_src,
    input logic              load_dst,
    input logic [AW-1:0]     load_val,
    input logic [1:0]        src_mode,
    input logic [1:0]        dst_mode,
    input logic [1:0]        src_reload,
    input logic [1:0]        dst_reload,
    input logic [SIZE_W-1:0] elem_size,
    input logic              access,
    input logic              burst_end,
    input logic              block_end,
    input logic              txn_end,
    input logic [AW-1:0]     src_addr,
    input logic [AW-1:0]     dst_addr
);
    logic [AW-1:0] src_home, dst_home;
    logic          src_evt, dst_evt;
    logic          any_end;

    assign any_end = burst_end || block_end || txn_end;
    assign src_evt = (src_reload == 2'd3) ? txn_end :
                     (src_reload == 2'd2) ? (block_end || txn_end) :
                     (src_reload == 2'd1) ? any_end : 1'b0;
    assign dst_evt = (dst_reload == 2'd3) ? txn_end :
                     (dst_reload == 2'd2) ? (block_end || txn_end) :
                     (dst_reload == 2'd1) ? any_end : 1'b0;

    // Independent record of the last loaded start addresses.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_home <= '0;
            dst_home <= '0;
        end else begin
            if (load_src) src_home <= load_val;
            if (load_dst) dst_home <= load_val;
        end
    end

    a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> (src_addr == '0 && dst_addr == '0));

    a_r2_load_src: assert property (@(posedge clk) disable iff (!rst_n)
        load_src |=> src_addr == $past(load_val));

    a_r2_load_dst: assert property (@(posedge clk) disable iff (!rst_n)
        load_dst |=> dst_addr == $past(load_val));

    a_r3_hold_src: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_src && !src_evt && (src_mode == 2'b00 || src_mode == 2'b11)) |=> $stable(src_addr));

    a_r4_up_src: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_src && !src_evt && access && src_mode == 2'b01)
        |=> src_addr == AW'($past(src_addr) + (AW'(1) << $past(elem_size))));

    a_r5_down_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_dst && !dst_evt && access && dst_mode == 2'b10)
        |=> dst_addr == AW'($past(dst_addr) - (AW'(1) << $past(elem_size))));

    a_r8_reload_src: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_src && src_evt) |=> src_addr == $past(src_home));

    a_r10_reload_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_dst && dst_evt && access) |=> dst_addr == $past(dst_home));

    a_r11_idle_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_dst && !dst_evt && !access) |=> $stable(dst_addr));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.AW(AW), .SIZE_W(SIZE_W)) i_chk (.*);

// File: tb/test_dma_addr_gen.sv
module test_dma_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_src, load_dst;
    logic [23:0] load_val;
    logic [1:0]  src_mode, dst_mode, src_reload, dst_reload, elem_size;
    logic        access, burst_end, block_end, txn_end;
    logic [23:0] src_addr, dst_addr;

    int checks = 0;
    int errors = 0;
    longint m_start [2];
    longint m_cur   [2];

    always #10 clk = ~clk;

    dma_addr_gen i_dma_addr_gen (
        .clk(clk), .rst_n(rst_n), .load_src(load_src), .load_dst(load_dst),
        .load_val(load_val), .src_mode(src_mode), .dst_mode(dst_mode),
        .src_reload(src_reload), .dst_reload(dst_reload), .elem_size(elem_size),
        .access(access), .burst_end(burst_end), .block_end(block_end),
        .txn_end(txn_end), .src_addr(src_addr), .dst_addr(dst_addr)
    );

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural model of one clock for both sides.
    task automatic model_tick();
        longint modulus = 64'd1 << 24;
        longint stepv = 64'd1 << elem_size;
        for (int s = 0; s < 2; s++) begin
            bit ld = (s == 0) ? load_src : load_dst;
            int md = (s == 0) ? src_mode : dst_mode;
            int rl = (s == 0) ? src_reload : dst_reload;
            bit rel = (rl == 3 && txn_end) ||
                      (rl == 2 && (txn_end || block_end)) ||
                      (rl == 1 && (txn_end || block_end || burst_end));
            if (ld) begin
                m_start[s] = load_val;
                m_cur[s] = load_val;
            end else if (rel) begin
                m_cur[s] = m_start[s];
            end else if (access && md == 1) begin
                m_cur[s] = (m_cur[s] + stepv) % modulus;
            end else if (access && md == 2) begin
                m_cur[s] = (m_cur[s] - stepv + modulus) % modulus;
            end
        end
    endtask

    task automatic clear_strobes();
        load_src = 0; load_dst = 0; access = 0;
        burst_end = 0; block_end = 0; txn_end = 0;
    endtask

    // Inputs already set at a falling edge; advance one clock and compare.
    task automatic cyc(string req);
        model_tick();
        @(posedge clk);
        @(negedge clk);
        check(req, "src_addr", src_addr, m_cur[0]);
        check(req, "dst_addr", dst_addr, m_cur[1]);
        clear_strobes();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #4000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0;
        clear_strobes();
        load_val = 0; src_mode = 0; dst_mode = 0;
        src_reload = 0; dst_reload = 0; elem_size = 0;
        m_start[0] = 0; m_start[1] = 0; m_cur[0] = 0; m_cur[1] = 0;
        repeat (3) @(negedge clk);
        check("R1", "src_addr in reset", src_addr, 0);
        check("R1", "dst_addr in reset", dst_addr, 0);
        rst_n = 1;
        cyc("R1");

        // R2 loads
        load_src = 1; load_val = 24'h000100; cyc("R2");
        load_dst = 1; load_val = 24'h002000; cyc("R2");

        // R4 up on source, R3 hold on destination, size 1
        src_mode = 2'b01; dst_mode = 2'b00; elem_size = 0;
        for (int i = 0; i < 4; i++) begin access = 1; cyc("R4"); end
        // R5 down on destination with size 4, R6
        dst_mode = 2'b10; elem_size = 2;
        for (int i = 0; i < 3; i++) begin access = 1; cyc("R5"); end
        for (int sz = 0; sz < 4; sz++) begin
            elem_size = 2'(sz); access = 1; cyc("R6");
        end

        // R7 wrap both directions with size 8
        elem_size = 3;
        load_src = 1; load_dst = 1; load_val = 24'hFFFFFC; cyc("R7");
        access = 1; cyc("R7");
        check("R7", "src wrapped", src_addr, 24'h000004);
        load_dst = 1; load_val = 24'h000004; cyc("R7");
        access = 1; cyc("R7");
        check("R7", "dst wrapped", dst_addr, 24'hFFFFFC);

        // R8 burst reload on source, never on destination
        elem_size = 0; src_reload = 2'b01; dst_reload = 2'b00;
        load_src = 1; load_val = 24'h000400; cyc("R8");
        access = 1; cyc("R8");
        access = 1; cyc("R8");
        burst_end = 1; cyc("R8");
        check("R8", "src back at start", src_addr, 24'h000400);

        // R9 block policy ignores burst_end; reloads on block_end and txn_end
        src_reload = 2'b10;
        access = 1; cyc("R9");
        burst_end = 1; cyc("R9");
        check("R9", "block policy ignores burst", src_addr, 24'h000401);
        block_end = 1; cyc("R9");
        access = 1; cyc("R9");
        txn_end = 1; cyc("R9");
        // transaction policy ignores burst and block ends
        src_reload = 2'b11;
        access = 1; cyc("R9");
        block_end = 1; burst_end = 1; cyc("R9");
        check("R9", "txn policy ignores block", src_addr, 24'h000401);
        txn_end = 1; cyc("R9");
        // burst policy also fires on block_end
        src_reload = 2'b01; access = 1; cyc("R9");
        block_end = 1; cyc("R9");

        // R10 reload beats access in the same cycle
        access = 1; cyc("R10");
        access = 1; burst_end = 1; cyc("R10");
        check("R10", "reload wins", src_addr, 24'h000400);

        // R2 load beats reload and access
        load_src = 1; load_val = 24'h00ABCD; access = 1; txn_end = 1; cyc("R2");

        // R3 mode 11 holds
        src_mode = 2'b11; src_reload = 2'b00;
        for (int i = 0; i < 3; i++) begin access = 1; cyc("R3"); end

        // R11 destination reload must not touch source
        dst_reload = 2'b01; src_mode = 2'b01; src_reload = 2'b00;
        load_dst = 1; load_val = 24'h005000; cyc("R11");
        access = 1; cyc("R11");
        burst_end = 1; cyc("R11");

        // R11 mixed random traffic
        for (int i = 0; i < 400; i++) begin
            load_src   = ($urandom_range(0, 15) == 0);
            load_dst   = ($urandom_range(0, 15) == 0);
            load_val   = 24'($urandom);
            src_mode   = 2'($urandom);
            dst_mode   = 2'($urandom);
            src_reload = 2'($urandom);
            dst_reload = 2'($urandom);
            elem_size  = 2'($urandom);
            access     = 1'($urandom);
            burst_end  = ($urandom_range(0, 3) == 0);
            block_end  = ($urandom_range(0, 7) == 0);
            txn_end    = ($urandom_range(0, 15) == 0);
            cyc("R11");
        end

        finish_run();
    end
endmodule